// File: doc/BRIEF.md
# Hamming ECC Parity Accumulator

This block builds a 24-bit single-error-correcting, double-error-detecting Hamming code over a block of data while that block streams across an 8-bit or 16-bit bus. Each bit of the block has a weighted index: eight times its byte address, plus its bit position inside the byte. For every weight from 1 to 2048, the block keeps two parities. The even term covers the bits whose index has a 0 at that weight. The odd term covers the bits whose index has a 1 there. The three low weights describe the column, meaning the bit inside a byte. The nine upper weights describe the row, meaning the byte address.

A start pulse clears the parities and latches the bus width and the block length. The block length is programmed as half the byte count minus one, so the default setting of 255 selects 512 bytes. Data beats are then presented with a valid strobe. Once the last byte has been absorbed, the block stops accumulating and raises done. The parities are output in two forms: a 32-bit result word, and a three-byte code ready to be written to a spare area or compared with one. The code is not inverted, so a fully erased block (every byte 0xFF) produces a code of zero, not all ones.

A small state machine controls the flow. It has three states: ST_IDLE (after reset, nothing accepted), ST_ACCUM (beats are absorbed) and ST_HELD (block complete, result frozen). The transitions are named as follows:
- start, from any state, goes to ST_ACCUM.
- The beat carrying the last byte moves ST_ACCUM to ST_HELD.
- Reset goes to ST_IDLE.

Top module: `hecc_accum`

## Requirements
- R1: After reset, result and code are zero, busy and done are low, and the block is in ST_IDLE, where beats have no effect.
- R2: A start pulse zeroes all parities and restarts the byte address at 0. From the next cycle, busy is high and done is low.
- R3: Every byte of the block counts at address A, with each bit b having index 8*A+b. For weight bit k (0..11), the even parity is the XOR of all set bits whose index has bit k equal to 0, and the odd parity is the XOR of those with bit k equal to 1.
- R4: With wide_sel high at start, each beat carries two bytes: data_in[7:0] at address A and data_in[15:8] at A+1. With wide_sel low, only data_in[7:0] is used, and the upper half has no effect.
- R5: The block length is 2*(size_sel+1) bytes. wide_sel and size_sel are captured at the start pulse, and later changes have no effect. done rises in the cycle after the beat that carries the last byte, and never while busy is high.
- R6: Beats presented while done is high, while in ST_IDLE, or with beat_vld low leave result unchanged.
- R7: Result bits 11:0 hold the even parities for weights 1,2,...,2048 in ascending order. Bits 27:16 hold the odd parities in the same order. All other bits are zero.
- R8: code[7:0] = result[7:0], code[15:8] = result[23:16], code[19:16] = result[11:8], and code[23:20] = result[27:24].
- R9: The code is not inverted: a block of all-0xFF bytes gives code 0, and a block of all-zero bytes also gives code 0.
- R10: If start and beat_vld are high in the same cycle, start wins and that beat is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clear-and-begin pulse; latches width and length |
| beat_vld | input | 1 | Data beat valid strobe |
| data_in | input | 16 | Data beat; low byte is the lower address |
| wide_sel | input | 1 | 1 = 16-bit beats, 0 = 8-bit beats |
| size_sel | input | 8 | Block length setting, bytes/2 - 1 |
| result | output | 32 | Even parities in 11:0, odd parities in 27:16 |
| code | output | 24 | Packed three-byte ECC code |
| busy | output | 1 | Accumulating (ST_ACCUM) |
| done | output | 1 | Block complete (ST_HELD) |

## Verification
A start pulse and a data beat can fall in the same cycle. The bench raises both together, with all-ones data that would disturb the parities if it were absorbed. It then requires result to read zero on the next sample, and the block that follows to match a code computed from that block alone. A second collision is a start pulse in the middle of a block. The bench judges it by the immediate zeroing of result and by a correct code for the block fed after the restart.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_HELD  = 2'd2
    } hecc_state_e;

    localparam int unsigned COL_PAIRS = 3;
    localparam int unsigned RESULT_W  = 32;
    localparam int unsigned CODE_W    = 24;
    localparam int unsigned ODD_BASE  = 16;

endpackage

// File: rtl/hecc_seq.sv
module hecc_seq
    import hecc_pkg::*;
#(
    parameter int unsigned SIZE_W = 8,
    parameter int unsigned LANES  = 2,
    localparam int unsigned ADDR_W = SIZE_W + 1,
    localparam int unsigned CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              beat_vld,
    input  logic              wide_sel,
    input  logic [SIZE_W-1:0] size_sel,
    output logic              take,
    output logic [LANES-1:0]  lane_en,
    output logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              done
);

    hecc_state_e       state_q, state_d;
    logic [SIZE_W-1:0] size_q;
    logic              wide_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  step;
    logic [CNT_W-1:0]  next_cnt;
    logic [CNT_W-1:0]  blk_bytes;
    logic              end_hit;

    assign step      = wide_q ? CNT_W'(LANES) : CNT_W'(1);
    assign next_cnt  = {1'b0, addr_q} + step;
    assign blk_bytes = {1'b0, size_q, 1'b0} + CNT_W'(2);
    assign end_hit   = (next_cnt >= blk_bytes);
    assign base_addr = addr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured configuration and byte address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= '0;
            wide_q <= 1'b0;
            addr_q <= '0;
        end else if (start) begin
            size_q <= size_sel;
            wide_q <= wide_sel;
            addr_q <= '0;
        end else if (take) begin
            addr_q <= next_cnt[ADDR_W-1:0];
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_ACCUM;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ACCUM: if (beat_vld && end_hit) state_d = ST_HELD;
                ST_HELD:  state_d = ST_HELD;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ACCUM: busy = 1'b1;
            ST_HELD:  done = 1'b1;
            default:  ;
        endcase
        take = busy & beat_vld & ~start;
        for (int j = 0; j < int'(LANES); j++) begin
            lane_en[j] = take && ((j == 0) || wide_q) &&
                         (({1'b0, addr_q} + CNT_W'(j)) < blk_bytes);
        end
    end

endmodule

// File: rtl/hecc_lane.sv
module hecc_lane
    import hecc_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    localparam int unsigned NPAIR = COL_PAIRS + ADDR_W
) (
    input  logic [7:0]        byte_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic [NPAIR-1:0]  even_t,
    output logic [NPAIR-1:0]  odd_t
);

    logic row_p;

    always_comb begin
        even_t = '0;
        odd_t  = '0;
        row_p  = ^byte_in;
        // column weights: bit position inside the byte
        for (int k = 0; k < int'(COL_PAIRS); k++) begin
            for (int i = 0; i < 8; i++) begin
                if (((i >> k) & 1) == 1) begin
                    odd_t[k] = odd_t[k] ^ byte_in[i];
                end else begin
                    even_t[k] = even_t[k] ^ byte_in[i];
                end
            end
        end
        // row weights: byte address
        for (int r = 0; r < int'(ADDR_W); r++) begin
            if (addr[r]) begin
                odd_t[COL_PAIRS + r] = row_p;
            end else begin
                even_t[COL_PAIRS + r] = row_p;
            end
        end
        if (!en) begin
            even_t = '0;
            odd_t  = '0;
        end
    end

endmodule

// File: rtl/hecc_pack.sv
module hecc_pack
    import hecc_pkg::*;
#(
    parameter int unsigned NPAIR = 12
) (
    input  logic [NPAIR-1:0]    even_q,
    input  logic [NPAIR-1:0]    odd_q,
    output logic [RESULT_W-1:0] result,
    output logic [CODE_W-1:0]   code
);

    always_comb begin
        result = '0;
        result[NPAIR-1:0]          = even_q;
        result[ODD_BASE +: NPAIR]  = odd_q;
        code = {result[27:24], result[11:8], result[23:16], result[7:0]};
    end

endmodule

// File: rtl/hecc_accum.sv
module hecc_accum
    import hecc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              beat_vld,
    input  logic [15:0]       data_in,
    input  logic              wide_sel,
    input  logic [7:0]        size_sel,
    output logic [31:0]       result,
    output logic [23:0]       code,
    output logic              busy,
    output logic              done
);

    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned ADDR_W = SIZE_W + 1;
    localparam int unsigned NPAIR  = COL_PAIRS + ADDR_W;

    logic              take;
    logic [LANES-1:0]  lane_en;
    logic [ADDR_W-1:0] base_addr;
    logic [NPAIR-1:0]  even_t [LANES];
    logic [NPAIR-1:0]  odd_t  [LANES];
    logic [NPAIR-1:0]  even_sum, odd_sum;
    logic [NPAIR-1:0]  even_q, odd_q;

    hecc_seq #(.SIZE_W(SIZE_W), .LANES(LANES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .beat_vld  (beat_vld),
        .wide_sel  (wide_sel),
        .size_sel  (size_sel[SIZE_W-1:0]),
        .take      (take),
        .lane_en   (lane_en),
        .base_addr (base_addr),
        .busy      (busy),
        .done      (done)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        hecc_lane #(.ADDR_W(ADDR_W)) u_lane (
            .byte_in (data_in[8*j +: 8]),
            .addr    (base_addr + ADDR_W'(j)),
            .en      (lane_en[j]),
            .even_t  (even_t[j]),
            .odd_t   (odd_t[j])
        );
    end

    always_comb begin
        even_sum = '0;
        odd_sum  = '0;
        for (int j = 0; j < int'(LANES); j++) begin
            even_sum = even_sum ^ even_t[j];
            odd_sum  = odd_sum ^ odd_t[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            even_q <= '0;
            odd_q  <= '0;
        end else if (start) begin
            even_q <= '0;
            odd_q  <= '0;
        end else if (take) begin
            even_q <= even_q ^ even_sum;
            odd_q  <= odd_q ^ odd_sum;
        end
    end

    hecc_pack #(.NPAIR(NPAIR)) u_pack (
        .even_q (even_q),
        .odd_q  (odd_q),
        .result (result),
        .code   (code)
    );

endmodule

// File: rtl/hecc_chk.sv
module hecc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        beat_vld,
    input logic [31:0] result,
    input logic        busy,
    input logic        done
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !busy && !done && !start |=> !busy && !done && (result == 32'd0));

    assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && start |=> (result == 32'd0) && busy && !done);

    assert_state_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));

    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $rose(done) |-> $past(busy));

    assert_held_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed && done && !start |=> done && $stable(result));

    assert_gap_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed && busy && !beat_vld && !start |=> busy && $stable(result));

    assert_start_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        armed && start && beat_vld |=> (result == 32'd0));

endmodule

bind hecc_accum hecc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .beat_vld (beat_vld),
    .result   (result),
    .busy     (busy),
    .done     (done)
);

// File: tb/hecc_accum_test.sv
module hecc_accum_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        beat_vld = 1'b0;
    logic [15:0] data_in = '0;
    logic        wide_sel = 1'b0;
    logic [7:0]  size_sel = '0;
    logic [31:0] result;
    logic [23:0] code;
    logic        busy;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0] blk [0:511];

    always #4 clk = ~clk;

    hecc_accum uut (
        .clk(clk), .rst_n(rst_n), .start(start), .beat_vld(beat_vld),
        .data_in(data_in), .wide_sel(wide_sel), .size_sel(size_sel),
        .result(result), .code(code), .busy(busy), .done(done)
    );

    // fields: wide[23], size[22:15], kind[14:12], param[11:0]
    localparam logic [23:0] VEC [11] = '{
        {1'b1, 8'd255, 3'd1, 12'd0},
        {1'b0, 8'd255, 3'd0, 12'd0},
        {1'b1, 8'd255, 3'd3, 12'd0},
        {1'b0, 8'd255, 3'd3, 12'hFFF},
        {1'b1, 8'd255, 3'd3, 12'd11},
        {1'b1, 8'd255, 3'd2, 12'h05A},
        {1'b0, 8'd255, 3'd4, 12'd3},
        {1'b1, 8'd15,  3'd4, 12'd7},
        {1'b0, 8'd0,   3'd4, 12'd9},
        {1'b1, 8'd0,   3'd2, 12'd1},
        {1'b0, 8'd63,  3'd2, 12'd0}
    };

    function automatic logic [7:0] gen_byte(int kind, int param, int i);
        case (kind)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'(i) ^ 8'(param);
            3: return (i == (param >> 3)) ? (8'h01 << (param & 7)) : 8'h00;
            default: return 8'(i * 29 + param) ^ 8'(i >> 3);
        endcase
    endfunction

    task automatic load_blk(int kind, int param);
        for (int i = 0; i < 512; i++) blk[i] = gen_byte(kind, param, i);
    endtask

    function automatic logic [31:0] ref_result(int n);
        logic [11:0] ev = '0;
        logic [11:0] od = '0;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (blk[i][b]) begin
                    for (int k = 0; k < 12; k++) begin
                        if ((((i * 8 + b) >> k) & 1) == 1) od[k] = ~od[k];
                        else                               ev[k] = ~ev[k];
                    end
                end
            end
        end
        return {4'h0, od, 4'h0, ev};
    endfunction

    function automatic logic [23:0] ref_code(logic [31:0] r);
        return {r[27:24], r[11:8], r[23:16], r[7:0]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Feeds blk[0..] as a block; optionally pulses start first.
    task automatic run_block(bit w, int sz, bit do_start, int gap, bit scramble);
        int nb = 2 * (sz + 1);
        int st = w ? 2 : 1;
        if (do_start) begin
            @(negedge clk);
            start = 1'b1; wide_sel = w; size_sel = 8'(sz);
            @(negedge clk);
            start = 1'b0;
        end
        if (scramble) begin
            wide_sel = ~w;
            size_sel = ~8'(sz);
        end
        for (int a = 0; a < nb; a += st) begin
            if (a + st >= nb) begin
                check("R5 done low before last beat", {30'd0, busy, done}, 32'd2);
            end
            beat_vld = 1'b1;
            data_in  = w ? {blk[a+1], blk[a]} : {8'hC3, blk[a]};
            @(negedge clk);
            if (gap > 0 && ((a / st) % gap) == 0) begin
                beat_vld = 1'b0;
                data_in  = 16'hFFFF;
                @(negedge clk);
            end
        end
        beat_vld = 1'b0;
        data_in  = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R5 watchdog expired actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_r;
        logic [31:0] hold_r;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset result", result, 32'd0);
        check("R1 reset code", {8'd0, code}, 32'd0);
        check("R1 reset busy/done", {30'd0, busy, done}, 32'd0);

        // R1/R6: beats in idle ignored
        beat_vld = 1'b1; data_in = 16'hFFFF; wide_sel = 1'b1;
        repeat (4) @(negedge clk);
        beat_vld = 1'b0;
        check("R6 idle beats ignored", result, 32'd0);
        check("R1 idle stays idle", {30'd0, busy, done}, 32'd0);

        // vector table: R3 R4 R5 R7 R8 R9
        foreach (VEC[e]) begin
            bit w  = VEC[e][23];
            int sz = int'(VEC[e][22:15]);
            load_blk(int'(VEC[e][14:12]), int'(VEC[e][11:0]));
            run_block(w, sz, 1'b1, 0, 1'b0);
            exp_r = ref_result(2 * (sz + 1));
            check($sformatf("R3 R4 R7 vec%0d result", e), result, exp_r);
            check($sformatf("R8 vec%0d code", e), {8'd0, code}, {8'd0, ref_code(exp_r)});
            check($sformatf("R5 vec%0d done", e), {30'd0, busy, done}, 32'd1);
        end

        // R9: explicit known codes
        load_blk(1, 0);
        run_block(1'b1, 255, 1'b1, 0, 1'b0);
        check("R9 erased block code is zero", {8'd0, code}, 32'd0);
        load_blk(3, 0);
        run_block(1'b0, 255, 1'b1, 0, 1'b0);
        check("R7 single bit idx0 result", result, 32'h0000_0FFF);
        check("R8 single bit idx0 code", {8'd0, code}, 32'h000F_00FF);

        // R6: beats after done ignored
        hold_r = result;
        beat_vld = 1'b1; data_in = 16'h1234;
        repeat (5) @(negedge clk);
        beat_vld = 1'b0;
        check("R6 overrun result frozen", result, hold_r);
        check("R6 overrun done held", {31'd0, done}, 32'd1);

        // R2: restart mid-block
        load_blk(4, 17);
        @(negedge clk);
        start = 1'b1; wide_sel = 1'b1; size_sel = 8'd255;
        @(negedge clk);
        start = 1'b0;
        for (int a = 0; a < 10; a++) begin
            beat_vld = 1'b1; data_in = 16'hBEEF; @(negedge clk);
        end
        beat_vld = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 restart zeroes result", result, 32'd0);
        check("R2 restart busy", {30'd0, busy, done}, 32'd2);
        run_block(1'b1, 255, 1'b0, 0, 1'b0);
        check("R2 restart from address 0", result, ref_result(512));

        // R10: start and beat in the same cycle
        load_blk(4, 5);
        @(negedge clk);
        start = 1'b1; beat_vld = 1'b1; data_in = 16'hFFFF;
        wide_sel = 1'b0; size_sel = 8'd31;
        @(negedge clk);
        start = 1'b0; beat_vld = 1'b0;
        check("R10 colliding beat dropped", result, 32'd0);
        run_block(1'b0, 31, 1'b0, 0, 1'b0);
        check("R10 block after collision", result, ref_result(64));

        // R6: valid gaps inside a block
        load_blk(4, 40);
        run_block(1'b1, 127, 1'b1, 3, 1'b0);
        check("R6 gaps have no effect", result, ref_result(256));

        // R5: configuration captured at start
        load_blk(2, 8'h33);
        run_block(1'b1, 20, 1'b1, 0, 1'b1);
        check("R5 captured config result", result, ref_result(42));
        check("R5 captured config done", {31'd0, done}, 32'd1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule